// File: doc/BRIEF.md
# Multi-lane SPI host shift engine

This block is a software-driven SPI host that moves bytes over 1, 2, 4 or 8 data lanes. Software writes a small set of word registers to set the chip-select state, the serial clock divider, the idle level of the data lines and the lane width of the current operation. It then pushes up to four bytes by writing one word to the transmit port. The port address it writes selects how many bytes of that word go out on the wire.

While those bytes are shifted out, the engine captures the same number of bytes from the input lanes. Software polls the status register until the engine is idle and the receive flag is set, then reads the captured bytes from the receive port as one right-aligned word. Chip select is fully manual: software raises it before a command sequence and drops it afterwards. The engine itself never touches chip select, so a command, its address and its data can span many port writes.

The serial clock uses mode 0: it idles low, incoming data is sampled on the rising edge and outgoing data changes on the falling edge. For a write of width greater than one, only the lanes that carry data are driven. For a wide read, every lane is released so that the memory can drive it.

Top module: `spi_lane_engine`

## Requirements
- R1: After reset cs_n is 1, sclk is 0, sio_o is 8'h00, sio_oe is 8'h01 and the status word at 0x04 reads 32'h1.
- R2: A write to 0x18, 0x1C or 0x20 sends 1, 2 or 3 bytes, and a write to 0x14 sends 4 bytes. A transfer of B bytes on N lanes makes exactly 8*B/N rising sclk edges.
- R3: Bytes leave the written word lowest byte first (bits [7:0] first), each byte most significant bit first. On N lanes a group of N bits goes out on lanes N-1..0, with the earliest bit on lane N-1. Lanes at or above N, and all lanes between transfers, carry the idle level.
- R4: Bits [7:6] of the operation word at 0x30 select the lane width: 0 gives 1 lane, 1 gives 2, 2 gives 4 and 3 gives 8. The width is taken when a transfer starts, so one byte takes 8, 4, 2 or 1 sclk cycles.
- R5: The receive word at 0x24 holds the bytes captured in the last transfer. The last byte is in bits [7:0], earlier bytes are above it, and unused upper bytes are 0. Bits are sampled at each rising sclk edge, on sio_i[1] for 1 lane and on sio_i[N-1:0] for N>1 lanes, with lane N-1 as the most significant.
- R6: Status bit 0 is 1 exactly when no transfer is in progress. Status bit 2 becomes 1 when a transfer ends, and goes back to 0 when 0x24 is read or when a new transfer starts.
- R7: cs_n is 0 only while config bits 1 (manual enable) and 0 (assert) at 0x00 are both 1.
- R8: Config bit 16 at 0x00 sets the level placed on every lane that carries no data bit.
- R9: While enable bit 0 at 0x10 is 0, a transmit-port write is dropped: no sclk edge occurs and the status stays 32'h1. Clearing the bit during a transfer freezes sclk and the lanes until the bit is set again, and the transfer then completes normally.
- R10: sio_oe is 8'h01 for 1-lane operation. For wider operation it is 8'h00 when bit 23 (read) of the operation word is 1, and otherwise has lanes 0..N-1 set. In a read, the written data is ignored and all-ones filler is shifted out.
- R11: sclk is low whenever the engine is idle. Each sclk half-period lasts config bits [11:8] plus one system clock cycles, and output lanes change only while sclk is low.
- R12: A transmit-port write made while a transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| sclk | output | 1 | Serial clock, mode 0 |
| cs_n | output | 1 | Chip select, active low |
| sio_o | output | 8 | Lane output values |
| sio_oe | output | 8 | Lane output enables |
| sio_i | input | 8 | Lane input values |

## Verification
The bench builds the engine with the default 4-bit divider field. It programs half-periods of two and four system clocks, so that the sclk timing and the freeze under a cleared enable can be checked at more than one divider setting.

Looping the lane outputs back onto the inputs for 1-lane and for wide writes exposes byte order, bit order and lane order as a single receive-word value. A one-lane read loops the filler back as all ones, which shows that the written data was ignored. A wide read is fed from a free-running pattern and checked against the model's capture.

// File: rtl/spi_lane_pkg.sv
package spi_lane_pkg;
    localparam int WORD_W = 32;
    localparam int LANES = 8;
    localparam int CNT_W = $clog2(WORD_W + 1);

    localparam logic [7:0] A_CFG  = 8'h00;
    localparam logic [7:0] A_STAT = 8'h04;
    localparam logic [7:0] A_EN   = 8'h10;
    localparam logic [7:0] A_TX0  = 8'h14;
    localparam logic [7:0] A_TX3  = 8'h20;
    localparam logic [7:0] A_RX   = 8'h24;
    localparam logic [7:0] A_OP   = 8'h30;

    typedef enum logic [1:0] {
        LW1 = 2'd0,
        LW2 = 2'd1,
        LW4 = 2'd2,
        LW8 = 2'd3
    } lanew_e;

    function automatic logic [3:0] lane_num(lanew_e w);
        return 4'd1 << w;
    endfunction

    function automatic logic [LANES-1:0] lane_mask(logic [3:0] n);
        logic [LANES:0] m;
        m = (9'd1 << n) - 9'd1;
        return m[LANES-1:0];
    endfunction
endpackage

// File: rtl/spi_lane_regs.sv
module spi_lane_regs
    import spi_lane_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [7:0]       addr,
    input  logic [31:0]      wdata,
    output logic             cs_n,
    output logic             idle_lvl,
    output logic             en,
    output logic [DIV_W-1:0] div,
    output lanew_e           width,
    output logic             rd_mode,
    output logic             tx_req,
    output logic [2:0]       tx_bytes
);
    typedef struct packed {
        logic             cs_on;
        logic             cs_man;
        logic             idle;
        logic             en;
        logic [DIV_W-1:0] div;
        lanew_e           width;
        logic             rd;
    } regs_t;

    regs_t r_d, r_q;
    logic [7:0] off;
    logic unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        r_d = r_q;
        if (wr) begin
            case (addr)
                A_CFG: begin
                    r_d.cs_on  = wdata[0];
                    r_d.cs_man = wdata[1];
                    r_d.idle   = wdata[16];
                    r_d.div    = wdata[8 +: DIV_W];
                end
                A_EN: r_d.en = wdata[0];
                A_OP: begin
                    r_d.width = lanew_e'(wdata[7:6]);
                    r_d.rd    = wdata[23];
                end
                default: ;
            endcase
        end
        off      = addr - A_TX0;
        tx_req   = wr && (addr >= A_TX0) && (addr <= A_TX3) && (off[1:0] == 2'b00);
        tx_bytes = (off[3:2] == 2'd0) ? 3'd4 : {1'b0, off[3:2]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cs_n     = !(r_q.cs_on && r_q.cs_man);
    assign idle_lvl = r_q.idle;
    assign en       = r_q.en;
    assign div      = r_q.div;
    assign width    = r_q.width;
    assign rd_mode  = r_q.rd;
endmodule

// File: rtl/spi_lane_shift.sv
module spi_lane_shift
    import spi_lane_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DIV_W-1:0]  div,
    input  lanew_e            width,
    input  logic              rd_mode,
    input  logic              idle_lvl,
    input  logic              tx_req,
    input  logic [2:0]        tx_bytes,
    input  logic [WORD_W-1:0] tx_word,
    input  logic [LANES-1:0]  sio_i,
    input  logic              rx_pop,
    output logic              busy,
    output logic              sclk,
    output logic [LANES-1:0]  sio_o,
    output logic [LANES-1:0]  sio_oe,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);
    typedef struct packed {
        logic              busy;
        logic              sclk;
        logic [DIV_W-1:0]  cnt;
        logic [CNT_W-1:0]  left;
        lanew_e            wid;
        logic              rd;
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
        logic              rxv;
    } eng_t;

    eng_t s_d, s_q;
    lanew_e wid_e;
    logic rd_e;
    logic [3:0] nl;
    logic [LANES-1:0] lmask, smp, top_bits;

    always_comb begin
        wid_e = s_q.busy ? s_q.wid : width;
        rd_e  = s_q.busy ? s_q.rd : rd_mode;
        nl    = lane_num(wid_e);
        lmask = lane_mask(nl);
        smp   = (wid_e == LW1) ? {{(LANES-1){1'b0}}, sio_i[1]} : (sio_i & lmask);

        s_d = s_q;
        if (rx_pop) s_d.rxv = 1'b0;
        if (!s_q.busy) begin
            if (tx_req && en) begin
                s_d.busy = 1'b1;
                s_d.sclk = 1'b0;
                s_d.cnt  = '0;
                s_d.left = CNT_W'({tx_bytes, 3'b000});
                s_d.wid  = width;
                s_d.rd   = rd_mode;
                s_d.tx   = rd_mode ? '1 :
                           {tx_word[7:0], tx_word[15:8], tx_word[23:16], tx_word[31:24]};
                s_d.rx   = '0;
                s_d.rxv  = 1'b0;
            end
        end else if (en) begin
            if (s_q.cnt == div) begin
                s_d.cnt  = '0;
                s_d.sclk = !s_q.sclk;
                if (!s_q.sclk) begin
                    s_d.rx = (s_q.rx << nl) | {{(WORD_W-LANES){1'b0}}, smp};
                end else begin
                    s_d.tx   = s_q.tx << nl;
                    s_d.left = s_q.left - CNT_W'(nl);
                    if (s_q.left == CNT_W'(nl)) begin
                        s_d.busy = 1'b0;
                        s_d.rxv  = 1'b1;
                    end
                end
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end

        top_bits = s_q.tx[WORD_W-1 -: LANES] >> (4'd8 - nl);
        if (s_q.busy) sio_o = (top_bits & lmask) | (idle_lvl ? ~lmask : '0);
        else          sio_o = {LANES{idle_lvl}};
        if (wid_e == LW1) sio_oe = {{(LANES-1){1'b0}}, 1'b1};
        else              sio_oe = rd_e ? '0 : lmask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy     = s_q.busy;
    assign sclk     = s_q.sclk;
    assign rx_word  = s_q.rx;
    assign rx_valid = s_q.rxv;
endmodule

// File: rtl/spi_lane_engine.sv
module spi_lane_engine
    import spi_lane_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        sclk,
    output logic        cs_n,
    output logic [7:0]  sio_o,
    output logic [7:0]  sio_oe,
    input  logic [7:0]  sio_i
);
    logic             idle_lvl, en, rd_mode, tx_req, busy, rx_valid, rx_pop;
    logic [DIV_W-1:0] div;
    lanew_e           width;
    logic [2:0]       tx_bytes;
    logic [31:0]      rx_word;

    assign rx_pop = reg_rd && (reg_addr == A_RX);

    spi_lane_regs #(.DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .cs_n(cs_n), .idle_lvl(idle_lvl), .en(en), .div(div), .width(width),
        .rd_mode(rd_mode), .tx_req(tx_req), .tx_bytes(tx_bytes)
    );

    spi_lane_shift #(.DIV_W(DIV_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .en(en), .div(div), .width(width),
        .rd_mode(rd_mode), .idle_lvl(idle_lvl), .tx_req(tx_req), .tx_bytes(tx_bytes),
        .tx_word(reg_wdata), .sio_i(sio_i), .rx_pop(rx_pop), .busy(busy),
        .sclk(sclk), .sio_o(sio_o), .sio_oe(sio_oe), .rx_word(rx_word),
        .rx_valid(rx_valid)
    );

    always_comb begin
        case (reg_addr)
            A_STAT:  reg_rdata = {29'd0, rx_valid, 1'b0, !busy};
            A_RX:    reg_rdata = rx_word;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_lane_engine_chk.sv
module spi_lane_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       en,
    input logic       sclk,
    input logic       rx_pop,
    input logic       rx_valid,
    input logic [7:0] sio_o,
    input logic [7:0] sio_oe
);
    AST_SCLK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk); // R11

    AST_LANES_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(sio_o)); // R11

    AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !en) |=> $stable(sclk)); // R9

    AST_RX_POP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !busy) |=> !rx_valid); // R6

    AST_OE_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(sio_oe)); // R10
endmodule

bind spi_lane_engine spi_lane_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .en(en), .sclk(sclk),
    .rx_pop(rx_pop), .rx_valid(rx_valid), .sio_o(sio_o), .sio_oe(sio_oe)
);

// File: tb/spi_lane_engine_bench.sv
module spi_lane_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        sclk, cs_n;
    logic [7:0]  sio_o, sio_oe, sio_i, pat = 8'h5B;
    int          lb = 0;

    int vectors = 0, fails = 0, cycles = 0, edges = 0, high_cnt = 0;
    logic sclk_prev = 1'b0;

    always #4 clk = ~clk;

    assign sio_i = (lb == 1) ? {6'b0, sio_o[0], 1'b0} : (lb == 2) ? sio_o : pat;

    spi_lane_engine u_spi_lane_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .cs_n(cs_n),
        .sio_o(sio_o), .sio_oe(sio_oe), .sio_i(sio_i)
    );

    // behavioural reference model
    logic        m_cs_on, m_cs_man, m_idle, m_en, m_rd, m_brd, m_busy, m_sclk, m_rxv;
    int          m_div, m_cnt, m_w, m_bw;
    logic [31:0] m_rx;
    bit          q[$];

    function automatic bit is_tx(logic [7:0] a);
        return (a == 8'h14) || (a == 8'h18) || (a == 8'h1C) || (a == 8'h20);
    endfunction

    function automatic int tx_nb(logic [7:0] a);
        return (a == 8'h14) ? 4 : (int'(a) - 8'h14) / 4;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cs_on = 0; m_cs_man = 0; m_idle = 0; m_div = 0; m_en = 0; m_w = 0; m_rd = 0;
            m_bw = 0; m_brd = 0; m_busy = 0; m_sclk = 0; m_cnt = 0; m_rx = 0; m_rxv = 0;
            q.delete();
        end else begin
            int n;
            n = 1 << m_bw;
            if (reg_rd && reg_addr == 8'h24) m_rxv = 0;
            if (!m_busy) begin
                if (reg_wr && is_tx(reg_addr) && m_en) begin
                    m_bw = m_w; m_brd = m_rd; q.delete();
                    for (int b = 0; b < tx_nb(reg_addr); b++)
                        for (int i = 7; i >= 0; i--)
                            q.push_back(m_rd ? 1'b1 : reg_wdata[8*b+i]);
                    m_busy = 1; m_sclk = 0; m_cnt = 0; m_rx = 0; m_rxv = 0;
                end
            end else if (m_en) begin
                if (m_cnt == m_div) begin
                    m_cnt = 0;
                    if (!m_sclk) begin
                        m_sclk = 1;
                        if (n == 1) m_rx = (m_rx << 1) | 32'(sio_i[1]);
                        else        m_rx = (m_rx << n) | 32'(sio_i & 8'((1 << n) - 1));
                    end else begin
                        m_sclk = 0;
                        repeat (n) void'(q.pop_front());
                        if (q.size() == 0) begin m_busy = 0; m_rxv = 1; end
                    end
                end else m_cnt++;
            end
            if (reg_wr) begin
                case (reg_addr)
                    8'h00: begin m_cs_on = reg_wdata[0]; m_cs_man = reg_wdata[1];
                                 m_idle = reg_wdata[16]; m_div = int'(reg_wdata[11:8]); end
                    8'h10: m_en = reg_wdata[0];
                    8'h30: begin m_w = int'(reg_wdata[7:6]); m_rd = reg_wdata[23]; end
                    default: ;
                endcase
            end
        end
    end

    task automatic vec(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cycles, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (sclk && !sclk_prev) edges++;
        if (sclk) high_cnt++;
        sclk_prev = sclk;
        if (rst_n) begin
            int nw, n;
            logic nr;
            logic [7:0] mask, eo, eoe;
            nw = m_busy ? m_bw : m_w;
            nr = m_busy ? m_brd : m_rd;
            n = 1 << nw;
            mask = 8'((1 << n) - 1);
            eoe = (nw == 0) ? 8'h01 : (nr ? 8'h00 : mask);
            for (int j = 0; j < 8; j++)
                eo[j] = (m_busy && j < n) ? q[n-1-j] : m_idle;
            vec(sclk == m_sclk, "R11 sclk", 32'(sclk), 32'(m_sclk));
            vec(cs_n == !(m_cs_on && m_cs_man), "R7 cs_n", 32'(cs_n), 32'(!(m_cs_on && m_cs_man)));
            vec(sio_oe == eoe, "R10 sio_oe", 32'(sio_oe), 32'(eoe));
            vec(sio_o == eo, "R3 sio_o", 32'(sio_o), 32'(eo));
        end
        pat = {pat[6:0], pat[7] ^ pat[5] ^ pat[4] ^ pat[3]};
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 4000; i++) begin
            rd(8'h04, s);
            if (s[0]) break;
        end
    endtask

    task automatic xfer(logic [7:0] a, logic [31:0] d, logic [31:0] exp_rx, int exp_edges, string req);
        logic [31:0] v;
        edges = 0;
        wr(a, d);
        wait_idle();
        rd(8'h04, v); vec(v == 32'h5, "R6 done status", v, 32'h5);
        rd(8'h24, v); vec(v == exp_rx, req, v, exp_rx);
        rd(8'h04, v); vec(v == 32'h1, "R6 cleared by read", v, 32'h1);
        vec(edges == exp_edges, "R2 R4 sclk edges", 32'(edges), 32'(exp_edges));
    endtask

    initial begin
        logic [31:0] v;
        logic s0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        vec(cs_n == 1 && sclk == 0, "R1 cs_n/sclk", {cs_n, sclk}, 2'b10);
        vec(sio_oe == 8'h01 && sio_o == 8'h00, "R1 lanes", {sio_oe, sio_o}, 16'h0100);
        rd(8'h04, v); vec(v == 32'h1, "R1 status", v, 32'h1);

        wr(8'h00, 32'h0000_0101); @(negedge clk);
        vec(cs_n == 1, "R7 assert without manual enable", 32'(cs_n), 1);
        wr(8'h00, 32'h0000_0103); @(negedge clk);
        vec(cs_n == 0, "R7 manual assert", 32'(cs_n), 0);

        // R9: dropped while disabled
        lb = 1; edges = 0;
        wr(8'h14, 32'hAAAA_AAAA);
        repeat (10) @(negedge clk);
        rd(8'h04, v); vec(v == 32'h1, "R9 dropped write status", v, 32'h1);
        vec(edges == 0, "R9 dropped write edges", 32'(edges), 0);
        wr(8'h10, 32'h1);

        // R2 R3 R5: one lane loopback, all four byte counts
        xfer(8'h14, 32'hA1B2_C3D4, 32'hD4C3_B2A1, 32, "R3 R5 four bytes");
        xfer(8'h18, 32'hFFFF_FF77, 32'h0000_0077, 8, "R2 R5 one byte");
        xfer(8'h1C, 32'h0000_5A3C, 32'h0000_3C5A, 16, "R2 R5 two bytes");
        xfer(8'h20, 32'h0011_2233, 32'h0033_2211, 24, "R2 R5 three bytes");

        // R4: wide writes looped back on all lanes
        lb = 2;
        wr(8'h30, 32'h0000_0040);
        xfer(8'h14, 32'h0F1E_2D3C, 32'h3C2D_1E0F, 16, "R4 two lanes");
        wr(8'h30, 32'h0000_0080);
        xfer(8'h20, 32'h00C0_FFEE, 32'h00EE_FFC0, 6, "R4 four lanes");
        wr(8'h30, 32'h0000_00C0);
        xfer(8'h14, 32'hDEAD_BEEF, 32'hEFBE_ADDE, 4, "R4 eight lanes");

        // R10: wide read releases lanes; captured from the pattern
        lb = 0;
        wr(8'h30, 32'h0080_0080);
        edges = 0;
        wr(8'h1C, 32'h1234_5678);
        @(negedge clk);
        vec(sio_oe == 8'h00, "R10 wide read oe", 32'(sio_oe), 0);
        wait_idle();
        rd(8'h24, v); vec(v == m_rx && v[31:16] == 16'h0, "R5 wide read capture", v, m_rx);
        vec(edges == 4, "R4 wide read edges", 32'(edges), 4);

        // R10: one-lane read shifts filler, data ignored
        lb = 1;
        wr(8'h30, 32'h0080_0000);
        xfer(8'h1C, 32'h0000_1234, 32'h0000_FFFF, 16, "R10 filler");

        // R12: second write while busy ignored
        wr(8'h30, 32'h0);
        edges = 0;
        wr(8'h14, 32'h1122_3344);
        wr(8'h18, 32'h0000_0099);
        wait_idle();
        rd(8'h24, v); vec(v == 32'h4433_2211, "R12 busy write ignored", v, 32'h4433_2211);
        vec(edges == 32, "R12 edge count", 32'(edges), 32);

        // R9: pause mid-transfer
        wr(8'h18, 32'h0000_005A);
        repeat (4) @(negedge clk);
        wr(8'h10, 32'h0);
        s0 = sclk;
        repeat (12) @(negedge clk);
        vec(sclk == s0, "R9 sclk frozen", 32'(sclk), 32'(s0));
        rd(8'h04, v); vec(v[0] == 0, "R9 still busy", v, 32'h0);
        wr(8'h10, 32'h1);
        wait_idle();
        rd(8'h24, v); vec(v == 32'h5A, "R9 resumed result", v, 32'h5A);

        // R11: half-period from the divider
        high_cnt = 0;
        xfer(8'h18, 32'h0000_0011, 32'h11, 8, "R11 div1 data");
        vec(high_cnt == 16, "R11 high time div1", 32'(high_cnt), 16);
        wr(8'h00, 32'h0000_0303);
        high_cnt = 0;
        xfer(8'h18, 32'h0000_0022, 32'h22, 8, "R11 div3 data");
        vec(high_cnt == 32, "R11 high time div3", 32'(high_cnt), 32);

        // R8: idle level high
        wr(8'h00, 32'h0001_0103);
        @(negedge clk);
        vec(sio_o == 8'hFF, "R8 idle level", 32'(sio_o), 32'hFF);
        lb = 2;
        wr(8'h30, 32'h0000_0080);
        xfer(8'h18, 32'h0000_00C3, 32'hC3, 2, "R8 four lanes with idle high");

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule